// File: doc/BRIEF.md
# Physical Register Rename Unit

This block translates architectural register numbers into tags from a much larger pool of physical registers. At issue, each request may name two source registers and one destination. The sources are looked up through the speculative map. The destination receives a fresh tag taken from a free-list FIFO. The tag that the destination register held until then is reported, so the pipeline can carry it to retirement. Register values never move between structures: a physical entry holds its result in place, and this unit handles tags only.

At retirement, the committed map records the new tag of the retiring register, and the tag it replaces returns to the tail of the free list. A flush overwrites the speculative map with the committed map in one step. The free list is then rebuilt by a scan over every physical tag, which pushes each tag that the committed map does not reference. Reset uses the same scan, starting from an identity mapping. While the scan runs, while the free list is empty, and during the flush cycle itself, the unit raises a stall and does not accept rename requests.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, both maps are the identity (architectural register a maps to tag a). The stall stays high while the reset scan runs, for about NUM_PHYS cycles. Afterwards the free list holds tags NUM_ARCH to NUM_PHYS-1 in ascending order.
- R2: Source tags are combinational reads of the speculative map in the cycle of the request.
- R3: An accepted request with dst_valid=1 takes the tag at the head of the free list, in FIFO order. It reports the destination's previous tag, and the speculative map takes the new tag at the next clock edge. With dst_valid=0, no tag is consumed.
- R4: A source that names the same register as the destination of its own request reads the mapping from before that request's allocation.
- R5: The stall is high whenever the free list is empty. A request made while the stall is high changes neither map nor free list.
- R6: A retire writes the new tag into the committed map and appends the old tag to the tail of the free list.
- R7: A flush replaces the whole speculative map with the committed map at the clock edge. The stall is high in the flush cycle, and a request made in that cycle is ignored.
- R8: After a flush, the free list is rebuilt to hold exactly the tags that the committed map does not reference, in ascending order. The stall stays high until the rebuild finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_src0_arch | input | ARCH_W | First source register number |
| ren_src1_arch | input | ARCH_W | Second source register number |
| ren_dst_valid | input | 1 | Request has a destination |
| ren_dst_arch | input | ARCH_W | Destination register number |
| ren_src0_phys | output | PHYS_W | Tag of first source |
| ren_src1_phys | output | PHYS_W | Tag of second source |
| ren_dst_phys | output | PHYS_W | Tag offered to the destination (free-list head) |
| ren_dst_old_phys | output | PHYS_W | Previous tag of the destination |
| ren_stall | output | 1 | Request cannot be accepted this cycle |
| ret_valid | input | 1 | Retire of a destination |
| ret_arch | input | ARCH_W | Retiring register number |
| ret_new_phys | input | PHYS_W | Tag that becomes committed |
| ret_old_phys | input | PHYS_W | Tag released to the free list |
| flush | input | 1 | Restore the committed map and rebuild the free list |

## Verification
The assertions assume that no retire arrives during a flush or while a rebuild scan runs. They also assume that retire tags come from earlier accepted renames. Under those conditions, the free list never holds more than NUM_PHYS-NUM_ARCH tags, and a popped tag cannot reappear at the head one cycle later. The bench keeps to these conditions: it issues retires only while the stall comes from an empty free list or is low, and it builds each retire from tags that the unit handed out or from the identity mapping.

// File: rtl/rn_pkg.sv
// Shared constants and helpers for the rename unit.
// Assumes the physical pool is larger than the architectural register set.
package rn_pkg;
    localparam int RN_NUM_ARCH = 16;
    localparam int RN_NUM_PHYS = 160;

    // Next index of a circular pointer with a wrap point at depth-1.
    function automatic int unsigned rn_wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction
endpackage

// File: rtl/rn_map_table.sv
// Speculative and committed register maps.
// Speculative map: three read ports, one rename write, whole-map restore on flush.
// Committed map: one retire write, exported flat so the rebuild scan can read it.
// Assumes the environment does not retire in the same cycle as a flush.
module rn_map_table #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 160,
    localparam int ARCH_W = $clog2(NUM_ARCH),
    localparam int PHYS_W = $clog2(NUM_PHYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [ARCH_W-1:0]          rd0_arch,
    input  logic [ARCH_W-1:0]          rd1_arch,
    input  logic [ARCH_W-1:0]          rdd_arch,
    output logic [PHYS_W-1:0]          rd0_tag,
    output logic [PHYS_W-1:0]          rd1_tag,
    output logic [PHYS_W-1:0]          rdd_tag,
    input  logic                       spec_we,
    input  logic [ARCH_W-1:0]          spec_warch,
    input  logic [PHYS_W-1:0]          spec_wtag,
    input  logic                       cmt_we,
    input  logic [ARCH_W-1:0]          cmt_warch,
    input  logic [PHYS_W-1:0]          cmt_wtag,
    output logic [NUM_ARCH*PHYS_W-1:0] cmt_flat
);
    logic [PHYS_W-1:0] spec_q [NUM_ARCH];
    logic [PHYS_W-1:0] cmt_q  [NUM_ARCH];

    // Speculative lookups read the map from before any write in this cycle.
    always_comb begin
        rd0_tag = spec_q[rd0_arch];
        rd1_tag = spec_q[rd1_arch];
        rdd_tag = spec_q[rdd_arch];
    end

    // Speculative map: identity at reset, full restore on flush, rename write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) spec_q[i] <= PHYS_W'(i);
        end else if (flush) begin
            for (int i = 0; i < NUM_ARCH; i++) spec_q[i] <= cmt_q[i];
        end else if (spec_we) begin
            spec_q[spec_warch] <= spec_wtag;
        end
    end

    // Committed map: identity at reset, retire write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) cmt_q[i] <= PHYS_W'(i);
        end else if (cmt_we) begin
            cmt_q[cmt_warch] <= cmt_wtag;
        end
    end

    // Flatten the committed map for the rebuild scan.
    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_flat
        assign cmt_flat[g*PHYS_W +: PHYS_W] = cmt_q[g];
    end
endmodule

// File: rtl/rn_free_fifo.sv
// Circular FIFO of free physical tags with a synchronous clear.
// Assumes no push when full; a pop when empty is ignored.
module rn_free_fifo #(
    parameter int DEPTH  = 160,
    parameter int TAG_W  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    import rn_pkg::*;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic             do_pop;

    // Head and occupancy flags.
    always_comb begin
        head_tag = mem[rd_ptr];
        empty    = (count == '0);
        do_pop   = pop && !empty;
    end

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_tag;
    end

    // Pointer and count update; clear empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= PTR_W'(rn_wrap_inc(int'(wr_ptr), DEPTH));
            if (do_pop) rd_ptr <= PTR_W'(rn_wrap_inc(int'(rd_ptr), DEPTH));
            count <= count + CNT_W'(push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/rn_rebuild_scan.sv
// Walks every physical tag once, emitting those not referenced by the committed map.
// Starts at reset and on each flush; one tag per cycle, ascending.
// Assumes the committed map does not change while the scan is busy.
module rn_rebuild_scan #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 160,
    localparam int PHYS_W = $clog2(NUM_PHYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_ARCH*PHYS_W-1:0] cmt_flat,
    output logic                       busy,
    output logic                       push_valid,
    output logic [PHYS_W-1:0]          push_tag
);
    logic [PHYS_W-1:0] idx_q;
    logic [NUM_ARCH-1:0] hit;

    // One comparator per architectural register against the current index.
    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_cmp
        assign hit[g] = (cmt_flat[g*PHYS_W +: PHYS_W] == idx_q);
    end

    // Push the current index when no committed entry uses it.
    always_comb begin
        push_tag   = idx_q;
        push_valid = busy && (hit == '0);
    end

    // Index walk: restart on reset or flush, stop after the last tag.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            idx_q <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (idx_q == PHYS_W'(NUM_PHYS - 1)) busy <= 1'b0;
            else idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/rn_rename_unit.sv
// Register rename unit: speculative lookup, free-list allocation,
// retire into a committed map, and flush by whole-map restore plus free-list rebuild.
// Assumes no retire during a flush or a rebuild scan, and that retire tags are genuine.
module rn_rename_unit #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS,
    localparam int ARCH_W = $clog2(NUM_ARCH),
    localparam int PHYS_W = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src0_arch,
    input  logic [ARCH_W-1:0] ren_src1_arch,
    input  logic              ren_dst_valid,
    input  logic [ARCH_W-1:0] ren_dst_arch,
    output logic [PHYS_W-1:0] ren_src0_phys,
    output logic [PHYS_W-1:0] ren_src1_phys,
    output logic [PHYS_W-1:0] ren_dst_phys,
    output logic [PHYS_W-1:0] ren_dst_old_phys,
    output logic              ren_stall,
    input  logic              ret_valid,
    input  logic [ARCH_W-1:0] ret_arch,
    input  logic [PHYS_W-1:0] ret_new_phys,
    input  logic [PHYS_W-1:0] ret_old_phys,
    input  logic              flush
);
    localparam int CNT_W = $clog2(NUM_PHYS + 1);

    logic [NUM_ARCH*PHYS_W-1:0] cmt_flat;
    logic                       scan_busy, scan_push;
    logic [PHYS_W-1:0]          scan_tag;
    logic                       fl_push, fl_empty, alloc;
    logic [PHYS_W-1:0]          fl_push_tag;
    logic [CNT_W-1:0]           free_cnt;
    logic                       ret_take;

    // Accept and push steering.
    always_comb begin
        ren_stall   = flush || scan_busy || fl_empty;
        alloc       = ren_valid && ren_dst_valid && !ren_stall;
        ret_take    = ret_valid && !flush && !scan_busy;
        fl_push     = scan_busy ? scan_push : ret_take;
        fl_push_tag = scan_busy ? scan_tag  : ret_old_phys;
    end

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .rd0_arch   (ren_src0_arch),
        .rd1_arch   (ren_src1_arch),
        .rdd_arch   (ren_dst_arch),
        .rd0_tag    (ren_src0_phys),
        .rd1_tag    (ren_src1_phys),
        .rdd_tag    (ren_dst_old_phys),
        .spec_we    (alloc),
        .spec_warch (ren_dst_arch),
        .spec_wtag  (ren_dst_phys),
        .cmt_we     (ret_take),
        .cmt_warch  (ret_arch),
        .cmt_wtag   (ret_new_phys),
        .cmt_flat   (cmt_flat)
    );

    rn_free_fifo #(.DEPTH(NUM_PHYS), .TAG_W(PHYS_W)) i_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .push     (fl_push),
        .push_tag (fl_push_tag),
        .pop      (alloc),
        .head_tag (ren_dst_phys),
        .empty    (fl_empty),
        .count    (free_cnt)
    );

    rn_rebuild_scan #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (flush),
        .cmt_flat   (cmt_flat),
        .busy       (scan_busy),
        .push_valid (scan_push),
        .push_tag   (scan_tag)
    );
endmodule

// File: rtl/rn_rename_chk.sv
// Protocol checks for the rename unit, bound to every instance of the top.
module rn_rename_chk #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 160,
    localparam int ARCH_W = $clog2(NUM_ARCH),
    localparam int PHYS_W = $clog2(NUM_PHYS),
    localparam int CNT_W  = $clog2(NUM_PHYS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              ren_valid,
    input logic              ren_dst_valid,
    input logic [ARCH_W-1:0] ren_dst_arch,
    input logic [ARCH_W-1:0] ren_src0_arch,
    input logic [PHYS_W-1:0] ren_src0_phys,
    input logic [PHYS_W-1:0] ren_dst_phys,
    input logic              ren_stall,
    input logic [CNT_W-1:0]  free_cnt
);
    logic fire;
    assign fire = ren_valid && ren_dst_valid && !ren_stall;

    // R1
    reset_stall_chk: assert property (@(posedge clk) !rst_n |=> ren_stall);

    // R3
    fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ren_stall || ren_dst_phys != $past(ren_dst_phys)));

    // R4
    map_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((ren_src0_arch == $past(ren_dst_arch)) -> (ren_src0_phys == $past(ren_dst_phys))));

    // R5
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> ren_stall);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(NUM_PHYS - NUM_ARCH));

    // R7
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ren_stall);
endmodule

bind rn_rename_unit rn_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) i_chk (.*);

// File: tb/test_rn_rename_unit.sv
`timescale 1ns/100ps
module test_rn_rename_unit;
    localparam int NA = 16;
    localparam int NP = 160;
    localparam int AW = 4;
    localparam int PW = 8;
    // vector: src0, src1, dst, dst_valid, exp_src0, exp_src1, exp_dst, exp_old
    localparam int VW = 3*AW + 1 + 4*PW;
    localparam int NV = 6;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd1,  4'd2,  4'd3,  1'b1, 8'd1,  8'd2,  8'd16, 8'd3},
        {4'd3,  4'd3,  4'd3,  1'b1, 8'd16, 8'd16, 8'd17, 8'd16},
        {4'd0,  4'd3,  4'd5,  1'b0, 8'd0,  8'd17, 8'd18, 8'd5},
        {4'd5,  4'd4,  4'd4,  1'b1, 8'd5,  8'd4,  8'd18, 8'd4},
        {4'd4,  4'd15, 4'd15, 1'b1, 8'd18, 8'd15, 8'd19, 8'd15},
        {4'd15, 4'd3,  4'd0,  1'b1, 8'd19, 8'd17, 8'd20, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ren_valid = 1'b0, ren_dst_valid = 1'b0;
    logic [AW-1:0] ren_src0_arch = '0, ren_src1_arch = '0, ren_dst_arch = '0;
    logic [PW-1:0] ren_src0_phys, ren_src1_phys, ren_dst_phys, ren_dst_old_phys;
    logic ren_stall;
    logic ret_valid = 1'b0;
    logic [AW-1:0] ret_arch = '0;
    logic [PW-1:0] ret_new_phys = '0, ret_old_phys = '0;
    logic flush = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rn_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP)) i_rn_rename_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let the lookups settle, leave the rising edge to commit.
    task automatic ren(input logic v, input int s0, input int s1, input int d, input logic dv);
        @(negedge clk);
        ren_valid = v; ren_src0_arch = AW'(s0); ren_src1_arch = AW'(s1);
        ren_dst_arch = AW'(d); ren_dst_valid = dv;
        ret_valid = 1'b0; flush = 1'b0;
        #0.5;
    endtask

    task automatic idle();
        @(negedge clk);
        ren_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0;
        #0.5;
    endtask

    task automatic retire(input int a, input int nt, input int ot);
        @(negedge clk);
        ren_valid = 1'b0; flush = 1'b0;
        ret_valid = 1'b1; ret_arch = AW'(a); ret_new_phys = PW'(nt); ret_old_phys = PW'(ot);
        #0.5;
    endtask

    // Counts the stall cycles of a rebuild scan.
    task automatic wait_rebuild(output int n);
        n = 0;
        idle();
        while (ren_stall && n < 2*NP) begin
            n++;
            idle();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, last;
        repeat (3) @(posedge clk);
        // R1: reset state, identity lookups, stall while reset is held
        ren(1'b0, 7, 12, 0, 1'b0);
        chk("R1 stall in reset", int'(ren_stall), 1);
        chk("R1 identity src0", int'(ren_src0_phys), 7);
        chk("R1 identity src1", int'(ren_src1_phys), 12);
        rst_n = 1'b1;
        wait_rebuild(n);
        chk("R1 scan length", int'(n >= NP - 2 && n <= NP + 1), 1);

        // R2 R3 R4: vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            ren(1'b1, int'(v[VW-1 -: AW]), int'(v[VW-AW-1 -: AW]), int'(v[VW-2*AW-1 -: AW]), v[4*PW]);
            chk("R2 src0 lookup", int'(ren_src0_phys), int'(v[4*PW-1 -: PW]));
            chk("R4 src1 lookup", int'(ren_src1_phys), int'(v[3*PW-1 -: PW]));
            chk("R3 dst tag", int'(ren_dst_phys), int'(v[2*PW-1 -: PW]));
            chk("R3 old tag", int'(ren_dst_old_phys), int'(v[PW-1:0]));
            chk("R5 no stall", int'(ren_stall), 0);
        end

        // R6: retire two writes of register 3
        retire(3, 16, 3);
        retire(3, 17, 16);

        // R7: flush with a request in the same cycle
        @(negedge clk);
        ret_valid = 1'b0; flush = 1'b1;
        ren_valid = 1'b1; ren_dst_valid = 1'b1; ren_dst_arch = 4'd6;
        #0.5;
        chk("R7 stall on flush", int'(ren_stall), 1);
        ren(1'b0, 4, 3, 0, 1'b0);
        chk("R7 restore reg4", int'(ren_src0_phys), 4);
        chk("R6 committed reg3", int'(ren_src1_phys), 17);
        ren(1'b0, 6, 15, 0, 1'b0);
        chk("R7 flush-cycle rename ignored", int'(ren_src0_phys), 6);
        chk("R7 restore reg15", int'(ren_src1_phys), 15);
        chk("R8 stall during rebuild", int'(ren_stall), 1);
        wait_rebuild(n);

        // R8: rebuilt order is 3, 16, 18, 19, ...
        ren(1'b1, 0, 0, 1, 1'b1);
        chk("R8 first rebuilt tag", int'(ren_dst_phys), 3);
        ren(1'b1, 0, 0, 2, 1'b1);
        chk("R8 second rebuilt tag", int'(ren_dst_phys), 16);
        ren(1'b1, 0, 0, 5, 1'b1);
        chk("R8 third rebuilt tag", int'(ren_dst_phys), 18);

        // R5: drain the free list
        n = 0; last = -1;
        forever begin
            ren(1'b1, 0, 0, 10, 1'b1);
            if (ren_stall) break;
            last = int'(ren_dst_phys);
            n++;
        end
        chk("R5 tags before empty", n, NP - NA - 3);
        chk("R5 last tag", last, NP - 1);
        ren(1'b1, 10, 9, 9, 1'b1);
        chk("R5 stalled rename ignored reg10", int'(ren_src0_phys), NP - 1);
        ren(1'b0, 9, 0, 0, 1'b0);
        chk("R5 stalled rename ignored reg9", int'(ren_src0_phys), 9);
        chk("R5 stall while empty", int'(ren_stall), 1);

        // R6: a retire refills the list with the old tag
        retire(10, NP - 1, 10);
        ren(1'b1, 0, 0, 2, 1'b1);
        chk("R6 stall released", int'(ren_stall), 0);
        chk("R6 freed tag reused", int'(ren_dst_phys), 10);
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule